// File: doc/BRIEF.md
# Adaptive Bitplane Period Estimator

This block keeps the base display interval for binary-coded modulation of a scanned LED matrix. A scan sequencer shows bitplane k for `base_period << k` timer ticks. This block supplies `base_period` and keeps it close to what the hardware really achieves. The timer, the shifting of pixel data and the matrix pins all sit outside the block.

A configuration strobe captures the timer clock rate, the bitplane count, the row-pair count and the chain width in columns. The strobe seeds the estimate with five ticks per column. It also starts a sequential divider that works out a lower bound on the period. The bound comes from a 250 frames-per-second refresh ceiling spread over every row pair and every plane weight, and it is never allowed below a fixed platform minimum. Once the bound is known, `cfg_ready` rises.

After that, the sequencer reports each measured interval on a valid/ready stream. A report changes the estimate only when the plane that just finished displaying was plane 0. In that case it is folded in with a 7/8 recursive filter, and the result is raised to the bound if it falls below it. Back-pressure rules:

- `meas_ready` follows `cfg_ready`.
- A report is taken only on a cycle where both `meas_valid` and `meas_ready` are high.
- A report offered while `meas_ready` is low is not taken, and the block keeps no copy of it.
- The block never stalls once it is ready.

Top module: `bplane_period_est`

## Requirements
- R1: After reset, `base_period` and `floor_period` are 0, and `cfg_ready` and `meas_ready` are low.
- R2: Once `cfg_ready` is high, `floor_period` equals trunc(trunc(trunc(hz/250)/rows)/(2^planes − 1)), using the effective planes and rows. If that value is below the platform minimum (default 20), the minimum is used instead.
- R3: `cfg_ready` is low in the cycle after a strobe and rises no more than 34 cycles after the strobe edge. `meas_ready` always equals `cfg_ready`.
- R4: A strobe sets `base_period` to `cfg_width` × 5 in the next cycle.
- R5: An accepted plane-zero report sets `base_period` to (7·old + elapsed) / 8, truncated, in the next cycle. The sum is formed without overflow, even for the largest elapsed value.
- R6: If the value computed in R5 is below `floor_period`, `base_period` takes `floor_period` instead.
- R7: A report is a plane-zero report when `meas_prev_plane` equals 1, or when the effective plane count is 1 (in which case any tag value counts). Any other accepted report leaves `base_period` unchanged.
- R8: A report offered while `meas_ready` is low leaves `base_period` unchanged. This includes reports offered before the first configuration and reports offered while the bound is being computed.
- R9: The plane count is clamped into 1..8 and the row-pair count into 1..32. A value of 0 counts as 1, and a value above the maximum counts as the maximum.
- R10: A strobe given while a computation is still running restarts the computation. The resulting bound reflects only the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Configuration strobe, one cycle |
| cfg_timer_hz | input | 32 | Timer tick rate in Hz |
| cfg_planes | input | 4 | Bitplane count (clamped to 1..8) |
| cfg_rowpairs | input | 6 | Row-pair count (clamped to 1..32) |
| cfg_width | input | 16 | Chain width in columns |
| cfg_ready | output | 1 | Bound computed; reports accepted |
| meas_valid | input | 1 | Report valid |
| meas_ready | output | 1 | Report accepted when high together with valid |
| meas_elapsed | input | 32 | Measured interval in timer ticks |
| meas_prev_plane | input | 3 | Index of the plane loaded on the previous pass |
| base_period | output | 32 | Current smoothed base interval |
| floor_period | output | 32 | Computed lower bound |

## Verification
The estimate and the bound are both visible at the ports, so a wrong internal state shows up quickly. A bad divider step or a bad clamp gives a wrong `floor_period`, or moves the `cfg_ready` edge, within 34 cycles of a strobe. A wrong plane-zero decision, a wrong filter coefficient or a missed floor clamp changes `base_period` one cycle after the report that triggered it. A gate that lets in reports while not ready shows up the same way, one cycle after the report. A scoreboard predicts `base_period` after every report. Decay sequences and all-ones elapsed values are used to reach the clamp and the wide-sum cases.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  // Clamp a requested count into 1..hi
  function automatic int clamp_count(int v, int hi);
    if (v < 1) return 1;
    else if (v > hi) return hi;
    else return v;
  endfunction

endpackage

// File: rtl/bpe_divider.sv
module bpe_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  import bpe_pkg::*;

  localparam int CW = $clog2(W + 1);

  div_state_e   st_q;
  logic [W-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]   shifted, diff;

  assign shifted  = {rem_q, quo_q[W-1]};
  assign diff     = shifted - {1'b0, dsr_q};
  assign quotient = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DIV_IDLE;
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      st_q  <= DIV_RUN;
      rem_q <= '0;
      quo_q <= dividend;
      dsr_q <= divisor;
      cnt_q <= CW'(W);
      done  <= 1'b0;
    end else if (st_q == DIV_RUN) begin
      if (!diff[W]) begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        st_q <= DIV_IDLE;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/bpe_floor_unit.sv
module bpe_floor_unit #(
  parameter int FREQ_W       = 32,
  parameter int PER_W        = 32,
  parameter int MAX_PLANES   = 8,
  parameter int MAX_ROWPAIRS = 32,
  parameter int REFRESH_CAP  = 250,
  parameter int PLAT_MIN     = 20,
  parameter int PL_W         = 4,
  parameter int RP_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [FREQ_W-1:0] hz,
  input  logic [PL_W-1:0]   planes_raw,
  input  logic [RP_W-1:0]   rows_raw,
  output logic              ready,
  output logic [PER_W-1:0]  floor_val,
  output logic [PL_W-1:0]   planes_eff
);
  import bpe_pkg::*;

  logic [PL_W-1:0]       pe;
  logic [RP_W-1:0]       re;
  logic [MAX_PLANES:0]   weight_sum;
  logic [FREQ_W-1:0]     divisor;
  logic                  div_done;
  logic [FREQ_W-1:0]     quot;
  logic [PER_W-1:0]      quot_fit;
  logic [PER_W-1:0]      floor_next;

  assign pe = PL_W'(clamp_count(int'(planes_raw), MAX_PLANES));
  assign re = RP_W'(clamp_count(int'(rows_raw), MAX_ROWPAIRS));
  assign weight_sum = ({{MAX_PLANES{1'b0}}, 1'b1} << pe) - {{MAX_PLANES{1'b0}}, 1'b1};
  // Nested truncating divisions equal one division by the product
  assign divisor = FREQ_W'(REFRESH_CAP) * FREQ_W'(re) * FREQ_W'(weight_sum);

  bpe_divider #(.W(FREQ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cfg_start),
    .dividend (hz),
    .divisor  (divisor),
    .done     (div_done),
    .quotient (quot)
  );

  generate
    if (FREQ_W > PER_W) begin : g_sat
      assign quot_fit = (|quot[FREQ_W-1:PER_W]) ? '1 : quot[PER_W-1:0];
    end else begin : g_ext
      assign quot_fit = PER_W'(quot);
    end
  endgenerate

  assign floor_next = (quot_fit < PER_W'(PLAT_MIN)) ? PER_W'(PLAT_MIN) : quot_fit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready      <= 1'b0;
      floor_val  <= '0;
      planes_eff <= '0;
    end else if (cfg_start) begin
      ready      <= 1'b0;
      planes_eff <= pe;
    end else if (div_done) begin
      ready     <= 1'b1;
      floor_val <= floor_next;
    end
  end

endmodule

// File: rtl/bpe_smoother.sv
module bpe_smoother #(
  parameter int PER_W = 32,
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [WID_W-1:0] width_cols,
  input  logic             upd,
  input  logic [PER_W-1:0] elapsed,
  input  logic [PER_W-1:0] floor_val,
  output logic [PER_W-1:0] est
);
  localparam int AW = PER_W + 4;

  logic [WID_W+2:0] seed;
  logic [AW-1:0]    acc;
  logic [PER_W-1:0] filt, clamped;

  assign seed    = {3'b000, width_cols} * (WID_W + 3)'(5);
  assign acc     = ({4'b0000, est} << 3) - {4'b0000, est} + {4'b0000, elapsed};
  assign filt    = acc[PER_W+2:3];
  assign clamped = (filt < floor_val) ? floor_val : filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         est <= '0;
    else if (seed_load) est <= PER_W'(seed);
    else if (upd)       est <= clamped;
  end

endmodule

// File: rtl/bplane_period_est.sv
module bplane_period_est #(
  parameter int FREQ_W       = 32,
  parameter int PER_W        = 32,
  parameter int WID_W        = 16,
  parameter int MAX_PLANES   = 8,
  parameter int MAX_ROWPAIRS = 32,
  parameter int REFRESH_CAP  = 250,
  parameter int PLAT_MIN     = 20,
  localparam int PL_W  = $clog2(MAX_PLANES + 1),
  localparam int RP_W  = $clog2(MAX_ROWPAIRS + 1),
  localparam int TAG_W = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [FREQ_W-1:0] cfg_timer_hz,
  input  logic [PL_W-1:0]   cfg_planes,
  input  logic [RP_W-1:0]   cfg_rowpairs,
  input  logic [WID_W-1:0]  cfg_width,
  output logic              cfg_ready,
  input  logic              meas_valid,
  output logic              meas_ready,
  input  logic [PER_W-1:0]  meas_elapsed,
  input  logic [TAG_W-1:0]  meas_prev_plane,
  output logic [PER_W-1:0]  base_period,
  output logic [PER_W-1:0]  floor_period
);

  logic [PL_W-1:0] planes_eff;
  logic            zero_done;
  logic            take;

  bpe_floor_unit #(
    .FREQ_W(FREQ_W), .PER_W(PER_W), .MAX_PLANES(MAX_PLANES),
    .MAX_ROWPAIRS(MAX_ROWPAIRS), .REFRESH_CAP(REFRESH_CAP),
    .PLAT_MIN(PLAT_MIN), .PL_W(PL_W), .RP_W(RP_W)
  ) u_floor (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .hz         (cfg_timer_hz),
    .planes_raw (cfg_planes),
    .rows_raw   (cfg_rowpairs),
    .ready      (cfg_ready),
    .floor_val  (floor_period),
    .planes_eff (planes_eff)
  );

  assign meas_ready = cfg_ready;
  // Plane 0 finished showing when plane 1 was the one loaded last,
  // or when there is only a single plane
  assign zero_done  = (planes_eff == PL_W'(1)) || (meas_prev_plane == TAG_W'(1));
  assign take       = meas_valid && meas_ready && zero_done;

  bpe_smoother #(.PER_W(PER_W), .WID_W(WID_W)) u_smooth (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (cfg_start),
    .width_cols (cfg_width),
    .upd        (take),
    .elapsed    (meas_elapsed),
    .floor_val  (floor_period),
    .est        (base_period)
  );

endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
  parameter int PER_W    = 32,
  parameter int WID_W    = 16,
  parameter int PL_W     = 4,
  parameter int TAG_W    = 3,
  parameter int PLAT_MIN = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic [WID_W-1:0] cfg_width,
  input logic             cfg_ready,
  input logic             meas_valid,
  input logic             meas_ready,
  input logic [TAG_W-1:0] meas_prev_plane,
  input logic [PL_W-1:0]  planes_eff,
  input logic [PER_W-1:0] base_period,
  input logic [PER_W-1:0] floor_period
);
  logic acc, plane0;
  assign acc    = meas_valid && meas_ready;
  assign plane0 = (planes_eff == PL_W'(1)) || (meas_prev_plane == TAG_W'(1));

  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !cfg_ready);

  assert_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> base_period == PER_W'($past(cfg_width)) * PER_W'(5));

  assert_floor_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> floor_period >= PER_W'(PLAT_MIN));

  assert_floor_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && !cfg_start) |=> ($stable(floor_period) && cfg_ready));

  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && plane0 && !cfg_start) |=> base_period >= floor_period);

  assert_other_plane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !plane0 && !cfg_start) |=> $stable(base_period));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !cfg_start) |=> $stable(base_period));

endmodule

bind bplane_period_est bpe_checker #(
  .PER_W(PER_W), .WID_W(WID_W), .PL_W(PL_W), .TAG_W(TAG_W), .PLAT_MIN(PLAT_MIN)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_start       (cfg_start),
  .cfg_width       (cfg_width),
  .cfg_ready       (cfg_ready),
  .meas_valid      (meas_valid),
  .meas_ready      (meas_ready),
  .meas_prev_plane (meas_prev_plane),
  .planes_eff      (planes_eff),
  .base_period     (base_period),
  .floor_period    (floor_period)
);

// File: tb/sim_bplane_period_est.sv
`timescale 1ns/1ps
module sim_bplane_period_est;
  localparam longint PMIN = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_timer_hz = '0;
  logic [3:0]  cfg_planes = '0;
  logic [5:0]  cfg_rowpairs = '0;
  logic [15:0] cfg_width = '0;
  logic        cfg_ready, meas_ready;
  logic        meas_valid = 1'b0;
  logic [31:0] meas_elapsed = '0;
  logic [2:0]  meas_prev_plane = '0;
  logic [31:0] base_period, floor_period;

  always #2.5 clk = ~clk;

  bplane_period_est u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_timer_hz(cfg_timer_hz),
    .cfg_planes(cfg_planes), .cfg_rowpairs(cfg_rowpairs), .cfg_width(cfg_width),
    .cfg_ready(cfg_ready), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_elapsed(meas_elapsed), .meas_prev_plane(meas_prev_plane),
    .base_period(base_period), .floor_period(floor_period)
  );

  int total = 0;
  int bad = 0;

  typedef struct { longint val; string req; } exp_t;
  exp_t sb[$];

  longint m_est = 0, m_floor = 0, m_peff = 1;
  bit     m_ready = 0;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampc(longint v, longint hi);
    if (v < 1) return 1;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint floor_of(longint hz, longint p, longint rp);
    longint f;
    f = hz / 250;
    f = f / clampc(rp, 32);
    f = f / ((64'd1 << clampc(p, 8)) - 1);
    if (f < PMIN) f = PMIN;
    return f;
  endfunction

  // Monitor: compare one expected item per edge after each driven report
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, longint'(base_period), e.val);
    end
  end

  task automatic meas(int tag, longint el, string req);
    exp_t e;
    @(negedge clk);
    check("R3", longint'(meas_ready), longint'(m_ready));
    meas_valid = 1'b1;
    meas_prev_plane = 3'(tag);
    meas_elapsed = 32'(el);
    if (m_ready && (tag == 1 || m_peff == 1)) begin
      m_est = (7 * m_est + el) / 8;
      if (m_est < m_floor) m_est = m_floor;
    end
    e.val = m_est;
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic strobe(longint hz, int p, int rp, int w);
    @(negedge clk);
    cfg_start = 1'b1;
    cfg_timer_hz = 32'(hz);
    cfg_planes = 4'(p);
    cfg_rowpairs = 6'(rp);
    cfg_width = 16'(w);
    @(posedge clk);
    #1;
    cfg_start = 1'b0;
    check("R3", longint'(cfg_ready), 0);
    check("R4", longint'(base_period), longint'(w) * 5);
    m_ready = 0;
    m_est = longint'(w) * 5;
    m_peff = clampc(p, 8);
    m_floor = floor_of(hz, p, rp);
  endtask

  task automatic wait_ready(string req);
    int n = 0;
    while (!cfg_ready && n < 60) begin
      @(posedge clk);
      #1;
      n++;
    end
    total++;
    if (n > 34 || !cfg_ready) begin
      bad++;
      $display("FAIL R3 actual=%0d cycles expected<=34", n);
    end
    check(req, longint'(floor_period), m_floor);
    m_ready = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", longint'(base_period), 0);
    check("R1", longint'(floor_period), 0);
    check("R1", longint'(cfg_ready), 0);
    check("R1", longint'(meas_ready), 0);
    @(negedge clk) rst_n = 1'b1;

    meas(1, 500, "R8");                 // no configuration yet

    strobe(16000000, 6, 16, 64);        // floor 63, seed 320
    wait_ready("R2");
    meas(1, 160, "R5");                 // 300
    meas(0, 5000, "R7");                // other plane, unchanged
    meas(3, 9999, "R7");
    meas(1, 7, "R5");                   // truncating 263
    for (int i = 0; i < 14; i++) meas(1, 0, "R6");  // decays onto the floor

    strobe(16000000, 6, 16, 64);        // restarted before done
    repeat (5) @(posedge clk);
    strobe(100000000, 4, 8, 200);       // floor 3333, seed 1000
    wait_ready("R10");
    meas(1, 1000, "R6");
    meas(1, 64'hFFFFFFFF, "R5");        // widest sum

    strobe(1000000, 8, 32, 10);         // below the minimum
    meas(1, 77, "R8");                  // offered while computing
    meas(1, 77, "R8");
    wait_ready("R2");

    strobe(50000000, 1, 4, 100);        // single plane, floor 50000
    wait_ready("R2");
    meas(0, 90000, "R7");
    meas(5, 800000, "R7");

    strobe(1000000, 0, 0, 30);          // zero counts clamp to 1
    wait_ready("R9");
    meas(2, 8000, "R9");
    strobe(200000000, 15, 63, 30);      // clamp to 8 planes, 32 rows
    wait_ready("R9");
    meas(4, 8000, "R7");

    repeat (3) @(posedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule